// File: doc/BRIEF.md
# Page-Mode Parallel Memory Access Controller

This controller sits between a system-side request handshake and an external 128K x 16 parallel memory. Each accepted request is a single word read or write with two byte enables. The controller drives the memory's active-low chip enable, write enable, output enable and two byte-lane strobes, a 17-bit word address and a shared bidirectional 16-bit data bus. It returns read data with a one-cycle valid pulse.

The controller keeps track of which four-word page is open, meaning chip enable is held low with address bits 16..2 fixed. A read that falls in the open page is a page-mode access: chip enable stays low, only the two low address bits move, and the result arrives after the short page access time. A request to any other page first raises chip enable for a pre-charge interval, then runs a full random access. A separate power sequencer reports through a ready input whether the memory can be accessed. While that input is low, no request is taken and the open page is closed.

Top module: `pgm_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, memCeN, memWeN, memOeN, memLbN and memUbN are all high, rspValid is low and reqReady equals memReady.
- R2: reqReady is high only while the controller is idle and memReady is high. An idle cycle with memReady low closes the open page: memCeN is high from the next cycle, so the next read pays the full random access time.
- R3: A read to a closed page drives chip enable and output enable low. Read data is sampled ACCESS_CYCLES clock edges after the accepting edge. rspValid is high for exactly one cycle, and reqReady returns in that same cycle.
- R4: A read whose address bits 16..2 match the open page keeps memCeN low and completes PAGE_CYCLES edges after acceptance. Address bits 16..2 never change while memCeN stays low.
- R5: A request to a page other than the open one raises memCeN for PRECHARGE_CYCLES cycles before the access. A read then completes PRECHARGE_CYCLES+ACCESS_CYCLES edges after acceptance, and a write PRECHARGE_CYCLES+WRITE_CYCLES+1.
- R6: A write holds memWeN low for WRITE_CYCLES cycles with the data driven. memWeN then rises while memCeN is still low and the data is still driven for one more cycle. reqReady returns WRITE_CYCLES+1 edges after acceptance, and the page stays open.
- R7: reqBe[1] selects the upper byte (memUbN low, data bits 15..8) and reqBe[0] selects the lower byte (memLbN low, data bits 7..0). A write changes only the enabled bytes of the stored word.
- R8: On a read, a lane whose enable is clear has its strobe high and returns zero in rspData. Enabled lanes return the stored bytes.
- R9: The controller drives the data bus only during write cycles. memOeN is never low while the bus is driven, and memOeN and memWeN are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReady | input | 1 | Power sequencer reports the memory usable |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted on this edge if valid |
| reqAddr | input | 17 | Word address; bits 16..2 page, bits 1..0 word |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBe | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 16 | Read data, disabled lanes zero |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memAddr | output | 17 | Memory word address |
| memDq | inout | 16 | Bidirectional data bus |

## Verification
Every result is due a fixed number of rising edges after the accepting edge. A page-hit read is due after PAGE_CYCLES edges and a closed-page read after ACCESS_CYCLES. A page-miss read is due after PRECHARGE_CYCLES+ACCESS_CYCLES, and a write's ready after WRITE_CYCLES+1, plus PRECHARGE_CYCLES on a page change. The bench drives and samples only on falling edges. After acceptance it counts edges until reqReady returns and compares that count with the value computed from the parameters; it reads rspData in that same cycle and confirms rspValid has dropped one cycle later. The memory model catches upper address changes under a low chip enable and overlapping output and write enables. Stored data is checked by reading it back.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECH,
    ST_READ,
    ST_WRITE,
    ST_WHOLD
  } pgm_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic ceLow;
    logic weLow;
    logic oeLow;
    logic lanesOn;
    logic dqDrive;
    logic capture;
  } pgm_strobe_t;

endpackage

// File: rtl/pgm_ctrl_fsm.sv
module pgm_ctrl_fsm
  import pgm_pkg::*;
#(
  parameter int PAGE_W           = 15,
  parameter int ACCESS_CYCLES    = 8,
  parameter int PAGE_CYCLES      = 3,
  parameter int PRECHARGE_CYCLES = 2,
  parameter int WRITE_CYCLES     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReady,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              reqReady,
  output pgm_strobe_t       strb
);

  localparam int MAX_AB = (ACCESS_CYCLES > PAGE_CYCLES) ? ACCESS_CYCLES : PAGE_CYCLES;
  localparam int MAX_CD = (PRECHARGE_CYCLES > WRITE_CYCLES) ? PRECHARGE_CYCLES : WRITE_CYCLES;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] ACC_LOAD  = CNT_W'(ACCESS_CYCLES - 1);
  localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PRE_LOAD  = CNT_W'(PRECHARGE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WRITE_CYCLES - 1);

  pgm_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              openValid;
  logic [PAGE_W-1:0] openPage;
  logic [PAGE_W-1:0] pendPage;
  logic              pendWrite;
  logic              accept;
  logic              cntDone;

  assign reqReady = (state == ST_IDLE) && memReady;
  assign accept   = reqReady && reqValid;
  assign cntDone  = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      openValid <= 1'b0;
      openPage  <= '0;
      pendPage  <= '0;
      pendWrite <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!memReady) begin
            openValid <= 1'b0;
          end else if (reqValid) begin
            pendWrite <= reqWrite;
            pendPage  <= reqPage;
            if (openValid && (reqPage != openPage)) begin
              state     <= ST_PRECH;
              cnt       <= PRE_LOAD;
              openValid <= 1'b0;
            end else begin
              state     <= reqWrite ? ST_WRITE : ST_READ;
              cnt       <= reqWrite ? WR_LOAD : (openValid ? PAGE_LOAD : ACC_LOAD);
              openValid <= 1'b1;
              openPage  <= reqPage;
            end
          end
        end
        ST_PRECH: begin
          if (cntDone) begin
            state     <= pendWrite ? ST_WRITE : ST_READ;
            cnt       <= pendWrite ? WR_LOAD : ACC_LOAD;
            openValid <= 1'b1;
            openPage  <= pendPage;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (cntDone) state <= ST_WHOLD;
          else         cnt   <= cnt - 1'b1;
        end
        ST_WHOLD: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.latchReq = accept;
    unique case (state)
      ST_IDLE:  strb.ceLow = openValid;
      ST_PRECH: strb.ceLow = 1'b0;
      ST_READ: begin
        strb.ceLow   = 1'b1;
        strb.oeLow   = 1'b1;
        strb.lanesOn = 1'b1;
        strb.capture = cntDone;
      end
      ST_WRITE: begin
        strb.ceLow   = 1'b1;
        strb.weLow   = 1'b1;
        strb.lanesOn = 1'b1;
        strb.dqDrive = 1'b1;
      end
      ST_WHOLD: begin
        strb.ceLow   = 1'b1;
        strb.lanesOn = 1'b1;
        strb.dqDrive = 1'b1;
      end
      default: strb.ceLow = 1'b0;
    endcase
  end

  // R2: an idle cycle without memReady leaves chip enable high next cycle
  a_r2_close_on_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !memReady) |=> !strb.ceLow);

  // R4: the open page cannot move while chip enable stays low
  a_r4_open_page_held: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ceLow && $past(strb.ceLow)) |-> $stable(openPage));

  // R5: leaving pre-charge always starts an access with chip enable low
  a_r5_prech_then_access: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_PRECH) && state != ST_PRECH) |-> strb.ceLow);

endmodule

// File: rtl/pgm_ctrl_dp.sv
module pgm_ctrl_dp
  import pgm_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgm_strobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] laneCapt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (strb.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign memLaneN[g]       = !(strb.lanesOn && beQ[g]);
    assign laneCapt[g*8 +: 8] = beQ[g] ? dqIn[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) rspData <= laneCapt;
    end
  end

  assign memCeN  = !strb.ceLow;
  assign memWeN  = !strb.weLow;
  assign memOeN  = !strb.oeLow;
  assign memAddr = addrQ;
  assign dqOut   = wdataQ;
  assign dqOe    = strb.dqDrive;

  // R9: bus drive and output enable never overlap
  a_r9_no_drive_with_oe: assert property (@(posedge clk) disable iff (!rstN)
    !(dqOe && !memOeN));

  // R9: output enable and write enable never low together
  a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  // R6: data still driven and chip enable low when write enable rises
  a_r6_data_at_we_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (dqOe && !memCeN));

  // R4: upper address is fixed while chip enable stays low
  a_r4_upper_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr[ADDR_W-1:2]));

  // R3: read valid is a single-cycle pulse
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int ACCESS_CYCLES    = 8,
  parameter int PAGE_CYCLES      = 3,
  parameter int PRECHARGE_CYCLES = 2,
  parameter int WRITE_CYCLES     = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memReady,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [16:0] reqAddr,
  input  logic        reqWrite,
  input  logic [1:0]  reqBe,
  input  logic [15:0] reqWdata,
  output logic        rspValid,
  output logic [15:0] rspData,
  output logic        memCeN,
  output logic        memWeN,
  output logic        memOeN,
  output logic        memLbN,
  output logic        memUbN,
  output logic [16:0] memAddr,
  inout  wire  [15:0] memDq
);

  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int PAGE_W = ADDR_W - 2;

  pgm_strobe_t       strb;
  logic [LANES-1:0]  laneN;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  pgm_ctrl_fsm #(
    .PAGE_W           (PAGE_W),
    .ACCESS_CYCLES    (ACCESS_CYCLES),
    .PAGE_CYCLES      (PAGE_CYCLES),
    .PRECHARGE_CYCLES (PRECHARGE_CYCLES),
    .WRITE_CYCLES     (WRITE_CYCLES)
  ) fsm_i (
    .clk      (clk),
    .rstN     (rstN),
    .memReady (memReady),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqPage  (reqAddr[ADDR_W-1:2]),
    .reqReady (reqReady),
    .strb     (strb)
  );

  pgm_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspData  (rspData),
    .memCeN   (memCeN),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memLaneN (laneN),
    .memAddr  (memAddr),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .dqIn     (memDq)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[1];
  assign memDq  = dqOe ? dqOut : 'z;

endmodule

// File: tb/pgm_ctrl_tb_top.sv
module pgm_ctrl_tb_top;

  localparam int ACC = 8;
  localparam int PG  = 3;
  localparam int PRE = 2;
  localparam int WR  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReady = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [16:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqBe = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        memCeN, memWeN, memOeN, memLbN, memUbN;
  logic [16:0] memAddr;
  wire  [15:0] memDq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pgm_ctrl #(
    .ACCESS_CYCLES (ACC),
    .PAGE_CYCLES (PG),
    .PRECHARGE_CYCLES (PRE),
    .WRITE_CYCLES (WR)
  ) dut_i (
    .clk (clk), .rstN (rstN), .memReady (memReady),
    .reqValid (reqValid), .reqReady (reqReady), .reqAddr (reqAddr),
    .reqWrite (reqWrite), .reqBe (reqBe), .reqWdata (reqWdata),
    .rspValid (rspValid), .rspData (rspData),
    .memCeN (memCeN), .memWeN (memWeN), .memOeN (memOeN),
    .memLbN (memLbN), .memUbN (memUbN), .memAddr (memAddr), .memDq (memDq)
  );

  // small memory model, indexed by the low address bits
  logic [15:0] mem [64];
  initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

  logic modelRd;
  assign modelRd = !memCeN && !memOeN && memWeN;
  assign memDq[7:0]  = (modelRd && !memLbN) ? mem[memAddr[5:0]][7:0]  : 8'bz;
  assign memDq[15:8] = (modelRd && !memUbN) ? mem[memAddr[5:0]][15:8] : 8'bz;

  always @(posedge memWeN) begin
    if (memCeN === 1'b0) begin
      if (!memLbN) mem[memAddr[5:0]][7:0]  <= memDq[7:0];
      if (!memUbN) mem[memAddr[5:0]][15:8] <= memDq[15:8];
    end
  end

  // pin monitors on falling edges
  int pageFaults = 0;
  int oeWeClash = 0;
  logic prevCeLow = 1'b0;
  logic [14:0] prevUpper = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!memCeN && prevCeLow && memAddr[16:2] != prevUpper) pageFaults++;
      if (!memOeN && !memWeN) oeWeClash++;
    end
    prevCeLow = !memCeN;
    prevUpper = memAddr[16:2];
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // enters and leaves on a falling edge with the controller idle
  task automatic runReq(input logic wr, input logic [1:0] be, input logic [16:0] a,
                        input logic [15:0] wd, input logic [15:0] expD,
                        input int expLat, input string tag);
    int lat;
    reqValid = 1'b1; reqWrite = wr; reqBe = be; reqAddr = a; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!reqReady) begin
      @(negedge clk);
      lat++;
    end
    check(lat == expLat, tag, "latency", lat, expLat);
    if (!wr) begin
      check(rspValid == 1'b1, tag, "rspValid at completion", rspValid, 1);
      check(rspData == expD, tag, "read data", rspData, expD);
    end
    @(negedge clk);
    check(rspValid == 1'b0, tag, "rspValid after one cycle", rspValid, 0);
  endtask

  // {write, be, addr, wdata, expData, latency, tag index}
  localparam int NV = 12;
  localparam logic [63:0] VEC [NV] = '{
    {1'b1, 2'b11, 17'h00010, 16'hA1B2, 16'h0000, 8'd7,  4'd6},
    {1'b1, 2'b11, 17'h00011, 16'hC3D4, 16'h0000, 8'd7,  4'd6},
    {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA1B2, 8'd3,  4'd4},
    {1'b0, 2'b11, 17'h00011, 16'h0000, 16'hC3D4, 8'd3,  4'd4},
    {1'b1, 2'b10, 17'h00011, 16'h55EE, 16'h0000, 8'd7,  4'd7},
    {1'b1, 2'b01, 17'h00010, 16'h9977, 16'h0000, 8'd7,  4'd7},
    {1'b0, 2'b11, 17'h00011, 16'h0000, 16'h55D4, 8'd3,  4'd7},
    {1'b0, 2'b10, 17'h00010, 16'h0000, 16'hA100, 8'd3,  4'd8},
    {1'b0, 2'b01, 17'h00010, 16'h0000, 16'h0077, 8'd3,  4'd8},
    {1'b1, 2'b11, 17'h00024, 16'h1357, 16'h0000, 8'd9,  4'd5},
    {1'b0, 2'b11, 17'h00010, 16'h0000, 16'hA177, 8'd10, 4'd5},
    {1'b0, 2'b11, 17'h00024, 16'h0000, 16'h1357, 8'd10, 4'd5}
  };

  function automatic string tagName(input logic [3:0] n);
    case (n)
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle pins during reset
    check({memCeN, memWeN, memOeN, memLbN, memUbN} == 5'b11111, "R1",
          "pins in reset", {memCeN, memWeN, memOeN, memLbN, memUbN}, 5'b11111);
    rstN = 1'b1;
    @(negedge clk);
    check({memCeN, memWeN, memOeN, memLbN, memUbN} == 5'b11111, "R1",
          "pins after reset", {memCeN, memWeN, memOeN, memLbN, memUbN}, 5'b11111);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R1", "rspValid/reqReady",
          {rspValid, reqReady}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      runReq(VEC[i][63], VEC[i][62:61], VEC[i][60:44], VEC[i][43:28],
             VEC[i][27:12], int'(VEC[i][11:4]), tagName(VEC[i][3:0]));
    end

    // R2: sequencer withdraws readiness with page 9 open
    check(memCeN == 1'b0, "R4", "page left open", memCeN, 0);
    memReady = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(reqReady == 1'b0, "R2", "reqReady while not ready", reqReady, 0);
    check(memCeN == 1'b1, "R2", "page closed while not ready", memCeN, 1);
    memReady = 1'b1;
    @(negedge clk);
    // R3: same page now costs the full random access
    runReq(1'b0, 2'b11, 17'h00024, 16'h0000, 16'h1357, ACC, "R3");

    check(pageFaults == 0, "R4", "upper address moved under low CE", pageFaults, 0);
    check(oeWeClash == 0, "R9", "OE and WE low together", oeWeClash, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule